// File: doc/BRIEF.md
# Down-Counting Event Timer Bank with Buffered Reload

This block holds a set of identical down-counting timer channels that act as event sources, plus one shared interrupt enable and pending register. Each channel has two software-written staging values, a count value and a compare value, and a small control field. The staging values never reach the running counter directly. They are copied into the working counter and working compare when software holds the update bit, or when a periodic channel wraps.

A channel counts down by one on each cycle in which the shared prescaled `tick` input is high, the channel is running, and the update bit is clear. A staged count of N therefore gives N+1 ticks between events. The tick at which the counter is already zero is the event. At that tick a periodic channel reloads from its staging values. A one-shot channel stays at zero and clears its own run bit. Each event sets the channel's pending flag. The `irq` output is high while any pending flag has its enable bit set.

Software reaches all state through one flat register port with a write strobe and a combinational read. Channel c, slot s sits at address 8*c+s. The interrupt register sits at address 8*NUM_CH.

Top module: `evt_timer_bank`

## Requirements
- R1: After reset, every staging value, control field, working counter, working compare, enable bit and pending flag is zero, and `irq` is low.
- R2: Slot 0 holds the count staging value and slot 1 holds the compare staging value. Slot 2 holds the control field: bit 0 is run, bit 1 is update, bit 2 is reload. All three read back what was last written.
- R3: While the update bit is set, the working counter (slot 3) and working compare (slot 4) are loaded from the staging values on every clock, and no tick decrements the counter. This also applies to a channel that is already running, so its count restarts at once.
- R4: One control write that sets run and clears update starts the channel. While running with update clear, each tick lowers the working counter by exactly one. A cycle without a tick leaves it unchanged.
- R5: With reload set, the tick that finds the counter at zero reloads both working values from the staging values. A staged count of N therefore gives an event every N+1 ticks.
- R6: With reload clear, the tick that finds the counter at zero raises the event, leaves the counter at zero and clears the run bit. Later ticks raise no further event.
- R7: Clearing the run bit freezes the working counter and leaves the staging values unchanged.
- R8: Writing a staging value without the update bit does not alter the working counter. The new value takes effect at the next reload.
- R9: In the interrupt register, bits NUM_CH+c (bits 9:5 by default) are the pending flags. A channel's event sets its flag. Writing 1 to a flag clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear wins.
- R10: Bits NUM_CH-1:0 of the interrupt register are read/write enables, one per channel. `irq` is high exactly when some pending flag has its enable set.
- R11: Slots 5 to 7 of a channel and addresses above 8*NUM_CH read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address: 8*channel+slot, or 8*NUM_CH for the interrupt register |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request, high while any enabled flag is pending |

## Verification
The bench runs the main counting path in three forms: staged with the update bit held while ticks arrive, free-running periodic, and one-shot. Holding update with ticks present shows that loading overrides counting. The periodic run counts the ticks between two events, which separates N from N+1 ticks per period. The one-shot run shows whether the run bit clears and whether later ticks raise new events. Further sequences cover a staging write made mid-period, an update forced on a running channel, and a stop with ticks still arriving. Together these show whether the staging values leak into the counter before a reload. Interrupt writes with 0 and with 1 in the flag positions, with the channel enabled and disabled, separate the sticky flag from the enable gating of `irq`.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   // Control field of one channel; bit order is software visible.
   typedef struct packed {
      logic reload;   // bit 2
      logic upd;      // bit 1
      logic run;      // bit 0
   } ctl_t;

   localparam int SLOT_W      = 3;
   localparam logic [SLOT_W-1:0] SLOT_CNT_BUF = 3'd0;
   localparam logic [SLOT_W-1:0] SLOT_CMP_BUF = 3'd1;
   localparam logic [SLOT_W-1:0] SLOT_CTL     = 3'd2;
   localparam logic [SLOT_W-1:0] SLOT_CNT_WRK = 3'd3;
   localparam logic [SLOT_W-1:0] SLOT_CMP_WRK = 3'd4;

endpackage

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
   import evt_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_cnt,
   input  logic             wr_cmp,
   input  logic             wr_ctl,
   input  logic [CNT_W-1:0] wval,
   output logic [CNT_W-1:0] cnt_buf,
   output logic [CNT_W-1:0] cmp_buf,
   output ctl_t             ctl,
   output logic [CNT_W-1:0] cnt_work,
   output logic [CNT_W-1:0] cmp_work,
   output logic             zero_evt
);

   logic counting;
   logic do_load;
   ctl_t wctl;

   assign wctl     = ctl_t'(wval[2:0]);
   assign counting = ctl.run && !ctl.upd && tick;
   assign zero_evt = counting && (cnt_work == '0);
   assign do_load  = ctl.upd || (zero_evt && ctl.reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_buf <= '0;
      end else if (wr_cnt) begin
         cnt_buf <= wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_ctl) begin
         ctl <= wctl;
      end else if (zero_evt && !ctl.reload) begin
         ctl.run <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_work <= '0;
      end else if (do_load) begin
         cnt_work <= cnt_buf;
      end else if (counting && !zero_evt) begin
         cnt_work <= cnt_work - 1'b1;
      end
   end

   generate
      if (HAS_CMP) begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmp_buf  <= '0;
               cmp_work <= '0;
            end else begin
               if (wr_cmp)  cmp_buf  <= wval;
               if (do_load) cmp_work <= cmp_buf;
            end
         end
      end else begin : g_no_cmp
         logic unused_cmp;
         assign unused_cmp = wr_cmp;
         assign cmp_buf    = '0;
         assign cmp_work   = '0;
      end
   endgenerate

   assert_upd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.upd |=> (cnt_work == $past(cnt_buf)));

   assert_dec_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctl.run && !ctl.upd && cnt_work != '0) |=> (cnt_work == $past(cnt_work) - 1'b1));

   assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ctl.upd) |=> $stable(cnt_work));

   assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && !ctl.reload && !wr_ctl) |=> (!ctl.run && cnt_work == '0));

   assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && ctl.reload) |=> (cnt_work == $past(cnt_buf)));

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq #(
   parameter int NUM_CH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [NUM_CH-1:0] wr_en_bits,
   input  logic [NUM_CH-1:0] wr_clr_bits,
   input  logic [NUM_CH-1:0] evt,
   output logic [NUM_CH-1:0] en,
   output logic [NUM_CH-1:0] pend,
   output logic              irq
);

   logic [NUM_CH-1:0] clr_eff;

   assign clr_eff = wr ? wr_clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= '0;
         pend <= '0;
      end else begin
         if (wr) en <= wr_en_bits;
         pend <= (pend & ~clr_eff) | evt;
      end
   end

   assign irq = |(en & pend);

   assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend) |=> ((($past(pend) & ~$past(clr_eff)) & ~pend) == '0));

   assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pend & $past(evt)) == $past(evt)));

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
   import evt_timer_pkg::*;
#(
   parameter int NUM_CH  = 5,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 6,
   parameter bit HAS_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic              irq
);

   localparam int CH_AW = ADDR_W - SLOT_W;
   localparam int IRQ_A = NUM_CH * 8;

   generate
      if (NUM_CH < 1 || 2 * NUM_CH > CNT_W) begin : g_bad_width
         $error("NUM_CH must be at least 1 and fit twice into CNT_W");
      end
      if (IRQ_A >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (CNT_W < 3) begin : g_bad_cnt
         $error("CNT_W must hold the control field");
      end
   endgenerate

   logic [CH_AW-1:0]  a_ch;
   logic [SLOT_W-1:0] a_slot;
   logic              irq_hit;

   assign a_ch    = addr[ADDR_W-1:SLOT_W];
   assign a_slot  = addr[SLOT_W-1:0];
   assign irq_hit = (addr == ADDR_W'(IRQ_A));

   logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_a, cmp_buf_a, cnt_work_a, cmp_work_a;
   ctl_t [NUM_CH-1:0]            ctl_a;
   logic [NUM_CH-1:0]            evt_a;
   logic [NUM_CH-1:0]            en_v, pend_v;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit = wr_en && (a_ch == CH_AW'(c));

         evt_timer_chan #(
            .CNT_W   (CNT_W),
            .HAS_CMP (HAS_CMP)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_cnt   (hit && a_slot == SLOT_CNT_BUF),
            .wr_cmp   (hit && a_slot == SLOT_CMP_BUF),
            .wr_ctl   (hit && a_slot == SLOT_CTL),
            .wval     (wdata),
            .cnt_buf  (cnt_buf_a[c]),
            .cmp_buf  (cmp_buf_a[c]),
            .ctl      (ctl_a[c]),
            .cnt_work (cnt_work_a[c]),
            .cmp_work (cmp_work_a[c]),
            .zero_evt (evt_a[c])
         );
      end
   endgenerate

   evt_timer_irq #(
      .NUM_CH (NUM_CH)
   ) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (wr_en && irq_hit),
      .wr_en_bits  (wdata[NUM_CH-1:0]),
      .wr_clr_bits (wdata[2*NUM_CH-1:NUM_CH]),
      .evt         (evt_a),
      .en          (en_v),
      .pend        (pend_v),
      .irq         (irq)
   );

   always_comb begin
      rdata = '0;
      if (irq_hit) begin
         rdata[2*NUM_CH-1:0] = {pend_v, en_v};
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (a_ch == CH_AW'(c)) begin
               case (a_slot)
                  SLOT_CNT_BUF: rdata = cnt_buf_a[c];
                  SLOT_CMP_BUF: rdata = cmp_buf_a[c];
                  SLOT_CTL:     rdata[2:0] = ctl_a[c];
                  SLOT_CNT_WRK: rdata = cnt_work_a[c];
                  SLOT_CMP_WRK: rdata = cmp_work_a[c];
                  default:      rdata = '0;
               endcase
            end
         end
      end
   end

   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_hit && a_slot > SLOT_CMP_WRK) |-> (rdata == '0));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!irq && evt_a == '0));

endmodule

// File: tb/evt_timer_bank_test.sv
`timescale 1ns/100ps
module evt_timer_bank_test;

   localparam int NCH = 5;
   localparam int CW  = 16;
   localparam int AW  = 6;
   localparam int IRQA = NCH * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [CW-1:0] wdata = '0;
   logic [CW-1:0] rdata;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   evt_timer_bank #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // Behavioural reference model
   int m_cb[NCH], m_mb[NCH], m_ctl[NCH], m_cw[NCH], m_mw[NCH];
   int m_en, m_pend;

   function automatic int ra(int c, int s);
      return c * 8 + s;
   endfunction

   function automatic int mdl_read(int a);
      int c, s;
      if (a == IRQA) return (m_pend << NCH) | m_en;
      c = a / 8; s = a % 8;
      if (c >= NCH) return 0;
      case (s)
         0: return m_cb[c];
         1: return m_mb[c];
         2: return m_ctl[c];
         3: return m_cw[c];
         4: return m_mw[c];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_cb[c] = 0; m_mb[c] = 0; m_ctl[c] = 0; m_cw[c] = 0; m_mw[c] = 0;
         end
         m_en = 0; m_pend = 0;
      end else begin
         int evt;
         int a;
         evt = 0;
         a = int'(addr);
         for (int c = 0; c < NCH; c++) begin
            int oc, ncw, nmw, nctl;
            oc = m_ctl[c]; ncw = m_cw[c]; nmw = m_mw[c]; nctl = oc;
            if ((oc & 2) != 0) begin
               ncw = m_cb[c]; nmw = m_mb[c];
            end else if ((oc & 1) != 0 && tick) begin
               if (m_cw[c] == 0) begin
                  evt |= (1 << c);
                  if ((oc & 4) != 0) begin
                     ncw = m_cb[c]; nmw = m_mb[c];
                  end else begin
                     nctl = oc & ~1;
                  end
               end else begin
                  ncw = m_cw[c] - 1;
               end
            end
            if (wr_en && a == ra(c, 2)) nctl = int'(wdata) & 7;
            if (wr_en && a == ra(c, 0)) m_cb[c] = int'(wdata);
            if (wr_en && a == ra(c, 1)) m_mb[c] = int'(wdata);
            m_cw[c] = ncw; m_mw[c] = nmw; m_ctl[c] = nctl;
         end
         if (wr_en && a == IRQA) begin
            m_pend = m_pend & ~((int'(wdata) >> NCH) & ((1 << NCH) - 1));
            m_en = int'(wdata) & ((1 << NCH) - 1);
         end
         m_pend = m_pend | evt;
      end
   end

   // Per-cycle comparison against the model (R10 irq, R11 read data)
   always @(negedge clk) begin
      #1.5;
      if (rst_n) begin
         n_chk++;
         if (int'(rdata) != mdl_read(int'(addr))) begin
            n_fail++;
            $display("FAIL R11 cycle compare addr %0d: got %0d exp %0d", addr, rdata, mdl_read(int'(addr)));
         end
         n_chk++;
         if (irq != (((m_en & m_pend) != 0) ? 1'b1 : 1'b0)) begin
            n_fail++;
            $display("FAIL R10 cycle compare irq: got %0b exp %0b", irq, (m_en & m_pend) != 0);
         end
      end
   end

   task automatic chk(input int got, input int exp, input string tag);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d exp %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = CW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input int exp, input string tag);
      @(negedge clk);
      addr = AW'(a);
      #0.5;
      chk(int'(rdata), exp, tag);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd(ra(0, 0), 0, "R1 count staging");
      rd(ra(0, 2), 0, "R1 control");
      rd(ra(0, 3), 0, "R1 working count");
      rd(IRQA, 0, "R1 interrupt reg");
      chk(int'(irq), 0, "R1 irq low");

      // R2 staging and control readback
      wr(ra(0, 0), 3);
      wr(ra(0, 1), 7);
      rd(ra(0, 0), 3, "R2 count staging");
      rd(ra(0, 1), 7, "R2 compare staging");

      // R3 manual update loads and blocks counting
      wr(ra(0, 2), 2);
      idle(1);
      rd(ra(0, 3), 3, "R3 working count loaded");
      rd(ra(0, 4), 7, "R3 working compare loaded");
      ticks(2);
      rd(ra(0, 3), 3, "R3 ticks ignored during update");

      // R4 start and decrement
      wr(ra(0, 2), 5);
      rd(ra(0, 2), 5, "R4 start clears update");
      ticks(1);
      rd(ra(0, 3), 2, "R4 one tick one decrement");
      idle(3);
      rd(ra(0, 3), 2, "R4 no tick no change");

      // R5 periodic wrap, R9 pending, R10 enable
      ticks(2);
      rd(ra(0, 3), 0, "R5 counter at zero");
      rd(IRQA, 0, "R5 no event before zero tick");
      ticks(1);
      rd(IRQA, 32, "R9 pending set on wrap");
      rd(ra(0, 3), 3, "R5 reload from staging");
      chk(int'(irq), 0, "R10 irq low without enable");
      wr(IRQA, 1);
      rd(IRQA, 33, "R9 write 0 keeps pending");
      chk(int'(irq), 1, "R10 irq high when enabled");
      wr(IRQA, 1 | 32);
      rd(IRQA, 1, "R9 write 1 clears pending");
      chk(int'(irq), 0, "R10 irq low after clear");
      ticks(3);
      rd(IRQA, 1, "R5 no event after 3 ticks");
      ticks(1);
      rd(IRQA, 33, "R5 event after N+1 ticks");
      wr(IRQA, 1 | 32);

      // R8 staging write without update
      wr(ra(0, 0), 1);
      rd(ra(0, 3), 3, "R8 working count unchanged");
      ticks(4);
      rd(ra(0, 3), 1, "R8 new value at next reload");
      wr(IRQA, 1 | 32);

      // R3 update on a running channel
      wr(ra(0, 0), 9);
      wr(ra(0, 2), 7);
      idle(1);
      rd(ra(0, 3), 9, "R3 running channel reloaded");
      ticks(1);
      rd(ra(0, 3), 9, "R3 held while update set");
      wr(ra(0, 2), 5);
      ticks(1);
      rd(ra(0, 3), 8, "R4 counting resumes");

      // R7 stop
      wr(ra(0, 2), 4);
      ticks(3);
      rd(ra(0, 3), 8, "R7 counter frozen");
      rd(ra(0, 0), 9, "R7 count staging kept");
      rd(ra(0, 1), 7, "R7 compare staging kept");
      rd(ra(0, 2), 4, "R7 control readback");

      // R6 one-shot on channel 2
      wr(ra(2, 0), 2);
      wr(ra(2, 2), 2);
      idle(1);
      wr(ra(2, 2), 1);
      ticks(2);
      rd(IRQA, 1, "R6 no event before zero tick");
      ticks(1);
      rd(IRQA, 1 | 128, "R6 event on zero tick");
      chk(int'(irq), 0, "R10 disabled channel no irq");
      rd(ra(2, 2), 0, "R6 run bit cleared");
      rd(ra(2, 3), 0, "R6 counter stays zero");
      wr(IRQA, 1 | 128);
      ticks(4);
      rd(IRQA, 1, "R6 no further events");

      // R11 unmapped addresses
      rd(6, 0, "R11 unused slot reads zero");
      wr(6, 16'hffff);
      rd(6, 0, "R11 unused slot write ignored");
      rd(ra(0, 0), 9, "R11 neighbour unchanged");
      wr(IRQA + 1, 16'hffff);
      rd(IRQA + 1, 0, "R11 above map reads zero");
      rd(IRQA, 1, "R11 interrupt reg unchanged");

      idle(2);
      summary();
   end

endmodule